// File: doc/BRIEF.md
# Microprogram Sequencer

This block steers a datapath from a fixed microprogram held in an on-chip ROM. A 6-bit microprogram counter selects one 21-bit microword per cycle. The microword carries a 12-bit control field that goes straight out to the datapath. It also carries a flag that loads a 4-bit mode register, a 2-bit branch selector and a 6-bit target address.

Two status flags come back from the datapath. Each is captured in a register before the next-address logic sees it. This rules out any combinational path from the control outputs, through the datapath, back into the sequencer. The cost is a fixed lag: a flag that rises before clock edge k can steer a branch only at edge k+1.

The next address is either the counter plus one or the target address held in the current word. The choice depends on the branch selector and on the registered flags. The mode register keeps its value across microwords until a word with the load flag set overwrites it.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `upc_out` to 0 and `mode_out` to 0 after that edge, and clears both registered condition flags.
- R2: When the current word's branch selector is 00, the counter advances by one on the next edge, and address 63 wraps to 0.
- R3: When the branch selector is 01, the counter loads the word's target address on the next edge.
- R4: When the branch selector is 10, the counter loads the target address if registered flag 0 is 1, and otherwise advances by one. Flag 1 has no effect on this choice.
- R5: When the branch selector is 11, the counter loads the target address if registered flag 1 is 1, and otherwise advances by one. Flag 0 has no effect on this choice.
- R6: `ctl_out` always equals the 12-bit control field of the word at the current `upc_out`, with no register in between.
- R7: When the current word's mode-load flag is set, `mode_out` takes control bits [3:0] on the next edge. Otherwise `mode_out` holds its value.
- R8: Each registered flag takes the value of `cond_in` at every edge. A flag change seen at edge k can therefore change the branch only at edge k+1.
- R9: The microprogram is as follows. Entries not listed have control = their own address, with selector 00 and no mode load.
  - Address 1: control 0x0A5, mode load, selector 00.
  - Address 2: control 0x002, selector 10, target 5.
  - Address 3: control 0x003, selector 01, target 2.
  - Address 5: control 0x05C, mode load, selector 00.
  - Address 6: control 0x006, selector 11, target 62.
  - Address 7: control 0x007, selector 01, target 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_in | input | 2 | Status flags from the datapath |
| ctl_out | output | 12 | Control field of the current microword |
| mode_out | output | 4 | Persistent mode register |
| upc_out | output | 6 | Current microprogram counter |

## Verification
The first pattern holds both flags low. This keeps the program in its wait loop at addresses 2 and 3, so plain increments are told apart from unconditional jumps. The second pattern raises flag 0 while the counter sits at address 2. The following address must still be 3, which separates a registered flag from a direct one. The third pattern raises each flag while the other flag's branch is current; this shows the unselected flag is ignored. A long run with a changing flag pattern and occasional resets then compares every address, control word and mode value against a cycle model, including the wrap from 63 to 0.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W  = 6;
    localparam int CTL_W   = 12;
    localparam int MODE_W  = 4;
    localparam int NCOND   = 2;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [1:0] {
        SEL_NEXT = 2'b00,
        SEL_JUMP = 2'b01,
        SEL_IF0  = 2'b10,
        SEL_IF1  = 2'b11
    } br_sel_e;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic              mode_ld;
        br_sel_e           sel;
        logic [ADDR_W-1:0] jaddr;
    } uword_t;

    localparam int WORD_W = $bits(uword_t);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [MODE_W-1:0] mode;
        logic [NCOND-1:0]  cond;
    } seq_state_t;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output uword_t            word
);

    // Microprogram: a wait loop on flag 0, a wait loop on flag 1,
    // and a tail that runs through the top of the address space.
    function automatic uword_t entry(input logic [ADDR_W-1:0] a);
        uword_t w;
        w.ctl     = CTL_W'(a);
        w.mode_ld = 1'b0;
        w.sel     = SEL_NEXT;
        w.jaddr   = '0;
        case (int'(a))
            1: begin
                w.ctl     = CTL_W'(12'h0A5);
                w.mode_ld = 1'b1;
            end
            2: begin
                w.sel   = SEL_IF0;
                w.jaddr = ADDR_W'(5);
            end
            3: begin
                w.sel   = SEL_JUMP;
                w.jaddr = ADDR_W'(2);
            end
            5: begin
                w.ctl     = CTL_W'(12'h05C);
                w.mode_ld = 1'b1;
            end
            6: begin
                w.sel   = SEL_IF1;
                w.jaddr = ADDR_W'(62);
            end
            7: begin
                w.sel   = SEL_JUMP;
                w.jaddr = ADDR_W'(6);
            end
            default: ;
        endcase
        return w;
    endfunction

    always_comb begin
        word = entry(addr);
    end

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
(
    input  logic [ADDR_W-1:0] pc_q,
    input  uword_t            word,
    input  logic [NCOND-1:0]  cond_q,
    output logic [ADDR_W-1:0] pc_next
);

    logic [ADDR_W-1:0] pc_inc;
    logic              take;

    // incrementer wraps naturally at the top of the address space
    always_comb begin
        pc_inc = pc_q + ADDR_W'(1);
    end

    always_comb begin
        case (word.sel)
            SEL_NEXT: take = 1'b0;
            SEL_JUMP: take = 1'b1;
            SEL_IF0:  take = cond_q[0];
            SEL_IF1:  take = cond_q[NCOND-1];
            default:  take = 1'b0;
        endcase
        pc_next = take ? word.jaddr : pc_inc;
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCOND-1:0]  cond_in,
    output logic [CTL_W-1:0]  ctl_out,
    output logic [MODE_W-1:0] mode_out,
    output logic [ADDR_W-1:0] upc_out
);

    seq_state_t        st_d, st_q;
    uword_t            cur_word;
    logic [ADDR_W-1:0] pc_next;
    logic [NCOND-1:0]  cond_q;

    useq_rom i_rom (
        .addr (st_q.pc),
        .word (cur_word)
    );

    useq_nextaddr i_next (
        .pc_q    (st_q.pc),
        .word    (cur_word),
        .cond_q  (st_q.cond),
        .pc_next (pc_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pc   = pc_next;
        st_d.cond = cond_in;
        if (cur_word.mode_ld) begin
            st_d.mode = cur_word.ctl[MODE_W-1:0];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cond_q   = st_q.cond;
    assign ctl_out  = cur_word.ctl;
    assign mode_out = st_q.mode;
    assign upc_out  = st_q.pc;

endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NCOND-1:0]  cond_in,
    input logic [NCOND-1:0]  cond_q,
    input uword_t            word,
    input logic [MODE_W-1:0] mode,
    input logic [ADDR_W-1:0] upc
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (upc == '0 && mode == '0 && cond_q == '0));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (word.sel == SEL_NEXT) |=> (upc == ADDR_W'($past(upc) + 1)));

    // R3
    jump_always_chk: assert property (@(posedge clk) disable iff (rst)
        (word.sel == SEL_JUMP) |=> (upc == $past(word.jaddr)));

    // R4
    jump_c0_chk: assert property (@(posedge clk) disable iff (rst)
        (word.sel == SEL_IF0 && cond_q[0]) |=> (upc == $past(word.jaddr)));

    // R4
    fall_c0_chk: assert property (@(posedge clk) disable iff (rst)
        (word.sel == SEL_IF0 && !cond_q[0]) |=> (upc == ADDR_W'($past(upc) + 1)));

    // R5
    jump_c1_chk: assert property (@(posedge clk) disable iff (rst)
        (word.sel == SEL_IF1 && cond_q[1]) |=> (upc == $past(word.jaddr)));

    // R5
    fall_c1_chk: assert property (@(posedge clk) disable iff (rst)
        (word.sel == SEL_IF1 && !cond_q[1]) |=> (upc == ADDR_W'($past(upc) + 1)));

    // R7
    mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        word.mode_ld |=> (mode == $past(word.ctl[MODE_W-1:0])));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word.mode_ld |=> $stable(mode));

    // R8
    cond_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cond_q == $past(cond_in)));

endmodule

bind useq_ctrl useq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cond_in (cond_in),
    .cond_q  (cond_q),
    .word    (cur_word),
    .mode    (mode_out),
    .upc     (upc_out)
);

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cond_in = 2'b00;
    logic [11:0] ctl_out;
    logic [3:0]  mode_out;
    logic [5:0]  upc_out;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    int    m_pc   = 0;
    int    m_mode = 0;
    int    m_c0   = 0;
    int    m_c1   = 0;
    string m_tag  = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_ctrl i_useq_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cond_in  (cond_in),
        .ctl_out  (ctl_out),
        .mode_out (mode_out),
        .upc_out  (upc_out)
    );

    // microprogram as listed in R9
    task automatic spec_word(input int a, output int ctl, output int ld,
                             output int sel, output int tgt);
        ctl = a; ld = 0; sel = 0; tgt = 0;
        case (a)
            1: begin ctl = 'h0A5; ld = 1; end
            2: begin sel = 2; tgt = 5; end
            3: begin sel = 1; tgt = 2; end
            5: begin ctl = 'h05C; ld = 1; end
            6: begin sel = 3; tgt = 62; end
            7: begin sel = 1; tgt = 6; end
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_edge(input logic [1:0] c, input logic r);
        int ctl, ld, sel, tgt, take;
        if (r) begin
            m_pc = 0; m_mode = 0; m_c0 = 0; m_c1 = 0; m_tag = "R1";
        end else begin
            spec_word(m_pc, ctl, ld, sel, tgt);
            case (sel)
                1:       take = 1;
                2:       take = m_c0;
                3:       take = m_c1;
                default: take = 0;
            endcase
            case (sel)
                0:       m_tag = "R2";
                1:       m_tag = "R3";
                2:       m_tag = "R4";
                default: m_tag = "R5";
            endcase
            if (ld != 0) m_mode = ctl & 15;
            m_pc = (take != 0) ? tgt : ((m_pc + 1) % 64);
            m_c0 = int'(c[0]);
            m_c1 = int'(c[1]);
        end
    endtask

    task automatic compare_all();
        int ctl, ld, sel, tgt;
        spec_word(m_pc, ctl, ld, sel, tgt);
        chk({m_tag, " upc"}, int'(upc_out), m_pc);
        chk("R6 R9 ctl", int'(ctl_out), ctl);
        chk("R7 mode", int'(mode_out), m_mode);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic [1:0] c, input logic r);
        cond_in = c;
        rst     = r;
        @(posedge clk);
        model_edge(c, r);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(2'b11, 1'b1);
        cyc(2'b11, 1'b1);
        chk("R1 upc after reset", int'(upc_out), 0);
        chk("R1 mode after reset", int'(mode_out), 0);

        // flags low: wait loop 2,3,2,3 (R2, R3, R4 fall-through)
        for (int i = 0; i < 10; i++) cyc(2'b00, 1'b0);
        chk("R7 mode loaded at address 1", int'(mode_out), 5);
        chk("R4 parked at loop head", int'(upc_out), 2);

        // flag 0 rises while at address 2: branch must lag by one edge
        cyc(2'b01, 1'b0);
        chk("R8 no branch on the edge that samples the flag", int'(upc_out), 3);
        cyc(2'b01, 1'b0);
        chk("R3 loop back", int'(upc_out), 2);
        cyc(2'b01, 1'b0);
        chk("R8 branch one edge later", int'(upc_out), 5);
        cyc(2'b00, 1'b0);
        chk("R7 mode reloaded at address 5", int'(mode_out), 12);

        // flag 0 held at address 6 must be ignored (R5)
        cyc(2'b01, 1'b0);
        chk("R5 flag 0 ignored", int'(upc_out), 7);
        cyc(2'b10, 1'b0);
        chk("R5 back to 6", int'(upc_out), 6);
        cyc(2'b00, 1'b0);
        chk("R5 jump on registered flag 1", int'(upc_out), 62);
        cyc(2'b00, 1'b0);
        cyc(2'b00, 1'b0);
        chk("R2 wrap 63 to 0", int'(upc_out), 0);

        // flag 1 at address 2 must be ignored (R4)
        for (int i = 0; i < 2; i++) cyc(2'b10, 1'b0);
        cyc(2'b10, 1'b0);
        cyc(2'b10, 1'b0);
        chk("R4 flag 1 ignored", int'(upc_out), 2);

        // long mixed run with occasional resets
        for (int i = 0; i < 600; i++) begin
            logic [1:0] c;
            c = 2'((i * 7 + i / 5) % 4);
            if ((i % 11) < 4) c = 2'b00;
            cyc(c, (i % 97) == 60);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule